// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is one DMA channel that works through a chain of descriptors stored in memory. Software writes descriptors into memory and pulses `go_i` with the address of the first one. The channel then fetches each descriptor as four 32-bit words over a single memory port and moves the data it describes in single beats. Each beat is a read from the current source address followed by a write to the current target address. When the byte count of a descriptor runs out, the channel follows the next pointer. It stops when that pointer carries the stop flag.

A descriptor has four words, fetched in this order: next pointer, source address, target address, command word. The command word sets the beat width, whether each address increments, byte reversal, pacing by a peripheral request, the burst size used for pacing, and the start and end events. A last descriptor that points back to the first forms a ring, and the ring runs until `abort_i` is raised. The current source and target addresses are always visible on ports, so the remaining byte count can be derived while the channel runs.

Top module: `ldma_channel`

## Requirements
- R1: After reset the channel is idle: `busy_o` is low, `mem_req_o` is low and no event output is asserted.
- R2: A descriptor is fetched as four word reads (`mem_size_o` = 2, `mem_we_o` low) at pointer+0, +4, +8, +12, in this order: next pointer, source, target, command. The pointer is taken with its low 4 bits cleared.
- R3: Each beat reads at the current source address and then writes at the current target address. Command bits [15:14] set the beat width: 1 means 1 byte, 2 means 2 bytes, 3 or 0 means 4 bytes. `mem_size_o` is 0, 1 or 2 for 1, 2 or 4 bytes. Data uses the low byte lanes, with byte 0 in bits [7:0].
- R4: Command bit 31 advances the source address by the width after every beat, and bit 30 does the same for the target address. When a bit is clear, that address stays fixed.
- R5: Command bits [12:0] hold the byte length. Each beat reduces it by the width, saturating at zero, so a descriptor makes ceil(length/width) beats.
- R6: A descriptor of length zero makes no data beats and goes straight on to its next pointer.
- R7: The next descriptor address is bits [31:4] of the next-pointer word, and bits [3:1] are ignored. If bit 0 is set, the channel goes idle after the descriptor and `busy_o` falls.
- R8: A ring (bit 0 clear on every descriptor) runs until `abort_i` is high at a descriptor or burst boundary. The channel then goes idle.
- R9: `evt_start_o` pulses for one cycle after the fetch of a descriptor whose command bit 22 is set. `evt_end_o` pulses for one cycle after the last beat of a descriptor whose bit 21 is set.
- R10: Command bit 18 reverses the byte order inside each beat before the write.
- R11: If command bit 29 or bit 28 is set, each burst waits for `req_valid_i` before its first read. Bits [17:16] set the burst size: 1, 2 and 3 mean 8, 16 and 32 bytes, and 0 means one beat.
- R12: An error response on any access pulses `evt_err_o` for one cycle and leaves the channel idle with no further memory access.
- R13: `cur_src_o` and `cur_tgt_o` show the live source and target addresses while the channel runs.
- R14: A memory request keeps its address, direction and write data unchanged until `mem_ack_i` or `mem_err_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start pulse, taken when idle |
| head_addr_i | input | AW | Address of the first descriptor |
| abort_i | input | 1 | Stop at the next descriptor or burst boundary |
| req_valid_i | input | 1 | Peripheral request for paced bursts |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address of the access |
| mem_size_o | output | 2 | 0/1/2 = 1/2/4 bytes |
| mem_wdata_o | output | 32 | Write data, low lanes |
| mem_rdata_i | input | 32 | Read data, low lanes |
| mem_ack_i | input | 1 | Access completed |
| mem_err_i | input | 1 | Access failed |
| busy_o | output | 1 | Channel is running |
| evt_start_o | output | 1 | Descriptor start event |
| evt_end_o | output | 1 | Descriptor end event |
| evt_err_o | output | 1 | Bus error event |
| cur_src_o | output | AW | Current source address |
| cur_tgt_o | output | AW | Current target address |

## Verification
Random single descriptors vary the width code, both increment flags, byte reversal and a length that is a multiple of the width. The memory model adds random wait states, so data moved, address stepping and swap order are checked apart from handshake timing. A fixed-source descriptor separates non-incrementing addresses from incrementing ones. A three-descriptor chain with junk in the low bits of its next pointers, a zero-length middle descriptor and a length that is not a multiple of the width checks pointer masking, skipping and saturating counts. Directed cases cover an endless ring stopped by abort, a paced transfer held back and then released one request at a time, and an error response on a target write.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

  localparam int CMD_LEN_W = 13;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LOAD, S_BURST, S_RD, S_WR, S_DONE, S_ERR
  } ldma_state_e;

  // Decoded fields of a descriptor command word
  typedef struct packed {
    logic                 inc_src;
    logic                 inc_tgt;
    logic                 pace_src;
    logic                 pace_tgt;
    logic                 ev_start;
    logic                 ev_end;
    logic                 swap;
    logic [CMD_LEN_W-1:0] len;
  } ldma_cmd_t;

  // Keep only the lanes of the beat, reversing them when asked
  function automatic logic [31:0] lane_pack(input logic [31:0] d,
                                            input logic        sw,
                                            input logic [1:0]  size);
    logic [31:0] r;
    unique case (size)
      2'd0:    r = {24'b0, d[7:0]};
      2'd1:    r = sw ? {16'b0, d[7:0], d[15:8]} : {16'b0, d[15:0]};
      default: r = sw ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ldma_cmd_decode.sv
module ldma_cmd_decode
  import ldma_pkg::*;
(
  input  logic [31:0] cmd_word,
  output ldma_cmd_t   cmd,
  output logic [2:0]  step_bytes,
  output logic [5:0]  burst_bytes,
  output logic [1:0]  size_code
);

  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{cmd_word[27:23], cmd_word[20:19], cmd_word[13]};

  always_comb begin
    cmd.inc_src  = cmd_word[31];
    cmd.inc_tgt  = cmd_word[30];
    cmd.pace_src = cmd_word[29];
    cmd.pace_tgt = cmd_word[28];
    cmd.ev_start = cmd_word[22];
    cmd.ev_end   = cmd_word[21];
    cmd.swap     = cmd_word[18];
    cmd.len      = cmd_word[CMD_LEN_W-1:0];

    unique case (cmd_word[15:14])
      2'd1:    begin step_bytes = 3'd1; size_code = 2'd0; end
      2'd2:    begin step_bytes = 3'd2; size_code = 2'd1; end
      default: begin step_bytes = 3'd4; size_code = 2'd2; end
    endcase

    unique case (cmd_word[17:16])
      2'd1:    burst_bytes = 6'd8;
      2'd2:    burst_bytes = 6'd16;
      2'd3:    burst_bytes = 6'd32;
      default: burst_bytes = {3'b0, step_bytes};
    endcase
  end

endmodule

// File: rtl/ldma_addr_unit.sv
module ldma_addr_unit #(
  parameter int AW = 32,
  parameter int LW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] tgt_init,
  input  logic [LW-1:0] len_init,
  input  logic          inc_src,
  input  logic          inc_tgt,
  input  logic [2:0]    step,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] tgt_q,
  output logic [LW-1:0] rem_q,
  output logic          last_beat
);

  logic [AW-1:0] src_d, tgt_d;
  logic [LW-1:0] rem_d;
  logic [AW-1:0] step_a;
  logic [LW-1:0] step_l;
  logic          upd;

  assign step_a    = AW'(step);
  assign step_l    = LW'(step);
  assign last_beat = (rem_q <= step_l);
  assign upd       = load | advance;

  always_comb begin
    src_d = src_q;
    tgt_d = tgt_q;
    rem_d = rem_q;
    if (load) begin
      src_d = src_init;
      tgt_d = tgt_init;
      rem_d = len_init;
    end else if (advance) begin
      if (inc_src) src_d = src_q + step_a;
      if (inc_tgt) tgt_d = tgt_q + step_a;
      rem_d = last_beat ? '0 : rem_q - step_l;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      tgt_q <= '0;
      rem_q <= '0;
    end else if (upd) begin
      src_q <= src_d;
      tgt_q <= tgt_d;
      rem_q <= rem_d;
    end
  end

  // R5: a beat never makes the remaining count grow
  a_r5_rem_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (rem_q <= $past(rem_q)));

  // R4: a cleared increment flag keeps the source address fixed
  a_r4_src_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && !inc_src) |=> $stable(src_q));

endmodule

// File: rtl/ldma_channel.sv
module ldma_channel
  import ldma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [AW-1:0] head_addr_i,
  input  logic          abort_i,
  input  logic          req_valid_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_ack_i,
  input  logic          mem_err_i,
  output logic          busy_o,
  output logic          evt_start_o,
  output logic          evt_end_o,
  output logic          evt_err_o,
  output logic [AW-1:0] cur_src_o,
  output logic [AW-1:0] cur_tgt_o
);

  localparam int WW     = 32;
  localparam int NWORDS = 4;
  localparam int WIDX_W = $clog2(NWORDS);
  localparam int LW     = CMD_LEN_W;
  localparam int W_NEXT = 0;
  localparam int W_SRC  = 1;
  localparam int W_TGT  = 2;
  localparam int W_CMD  = 3;

  ldma_state_e       state_q, state_d;
  logic [WIDX_W-1:0] widx_q, widx_d;
  logic [AW-1:0]     ptr_q, ptr_d;
  logic [WW-1:0]     data_q, data_d;
  logic [5:0]        bleft_q, bleft_d;
  logic [WW-1:0]     words_q [NWORDS];
  logic              word_we;
  logic              data_we;
  logic              ptr_we;
  logic              bleft_we;

  ldma_cmd_t         cmd;
  logic [2:0]        step;
  logic [5:0]        burst_bytes;
  logic [1:0]        size_code;
  logic              pace;
  logic              au_load, au_adv;
  logic [AW-1:0]     src_q, tgt_q;
  logic [LW-1:0]     rem_q;
  logic              last_beat;
  logic              unused_next_bits;

  assign unused_next_bits = ^words_q[W_NEXT][3:1];

  // Descriptor word registers, one enable per word
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     words_q[g] <= '0;
      else if (word_we && (widx_q == WIDX_W'(g)))     words_q[g] <= mem_rdata_i;
    end
  end

  ldma_cmd_decode u_dec (
    .cmd_word    (words_q[W_CMD]),
    .cmd         (cmd),
    .step_bytes  (step),
    .burst_bytes (burst_bytes),
    .size_code   (size_code)
  );

  assign pace = cmd.pace_src | cmd.pace_tgt;

  ldma_addr_unit #(.AW(AW), .LW(LW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (au_load),
    .advance   (au_adv),
    .src_init  (words_q[W_SRC][AW-1:0]),
    .tgt_init  (words_q[W_TGT][AW-1:0]),
    .len_init  (cmd.len),
    .inc_src   (cmd.inc_src),
    .inc_tgt   (cmd.inc_tgt),
    .step      (step),
    .src_q     (src_q),
    .tgt_q     (tgt_q),
    .rem_q     (rem_q),
    .last_beat (last_beat)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    widx_d   = widx_q;
    ptr_d    = ptr_q;
    data_d   = data_q;
    bleft_d  = bleft_q;
    word_we  = 1'b0;
    data_we  = 1'b0;
    ptr_we   = 1'b0;
    bleft_we = 1'b0;
    au_load  = 1'b0;
    au_adv   = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (go_i) begin
          ptr_d   = {head_addr_i[AW-1:4], 4'b0};
          ptr_we  = 1'b1;
          widx_d  = '0;
          state_d = S_FETCH;
        end
      end
      S_FETCH: begin
        if (mem_err_i) begin
          state_d = S_ERR;
        end else if (mem_ack_i) begin
          word_we = 1'b1;
          widx_d  = widx_q + 1'b1;
          if (widx_q == WIDX_W'(NWORDS - 1)) state_d = S_LOAD;
        end
      end
      S_LOAD: begin
        au_load = 1'b1;
        if (abort_i)            state_d = S_IDLE;
        else if (cmd.len == '0) state_d = S_DONE;
        else                    state_d = S_BURST;
      end
      S_BURST: begin
        if (abort_i) begin
          state_d = S_IDLE;
        end else if (!pace || req_valid_i) begin
          bleft_d  = burst_bytes;
          bleft_we = 1'b1;
          state_d  = S_RD;
        end
      end
      S_RD: begin
        if (mem_err_i) begin
          state_d = S_ERR;
        end else if (mem_ack_i) begin
          data_d  = mem_rdata_i;
          data_we = 1'b1;
          state_d = S_WR;
        end
      end
      S_WR: begin
        if (mem_err_i) begin
          state_d = S_ERR;
        end else if (mem_ack_i) begin
          au_adv   = 1'b1;
          bleft_d  = bleft_q - {3'b0, step};
          bleft_we = 1'b1;
          if (last_beat)                    state_d = S_DONE;
          else if (bleft_q <= {3'b0, step}) state_d = S_BURST;
          else                              state_d = S_RD;
        end
      end
      S_DONE: begin
        if (abort_i || words_q[W_NEXT][0]) begin
          state_d = S_IDLE;
        end else begin
          ptr_d   = {words_q[W_NEXT][AW-1:4], 4'b0};
          ptr_we  = 1'b1;
          widx_d  = '0;
          state_d = S_FETCH;
        end
      end
      S_ERR:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      widx_q  <= '0;
      ptr_q   <= '0;
      data_q  <= '0;
      bleft_q <= '0;
    end else begin
      state_q <= state_d;
      widx_q  <= widx_d;
      if (ptr_we)   ptr_q   <= ptr_d;
      if (data_we)  data_q  <= data_d;
      if (bleft_we) bleft_q <= bleft_d;
    end
  end

  // Memory port
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr_q + AW'({widx_q, 2'b00});
    mem_size_o  = 2'd2;
    mem_wdata_o = '0;
    unique case (state_q)
      S_FETCH: mem_req_o = 1'b1;
      S_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = src_q;
        mem_size_o = size_code;
      end
      S_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = tgt_q;
        mem_size_o  = size_code;
        mem_wdata_o = lane_pack(data_q, cmd.swap, size_code);
      end
      default: ;
    endcase
  end

  assign busy_o      = (state_q != S_IDLE);
  assign evt_start_o = (state_q == S_LOAD) && cmd.ev_start;
  assign evt_end_o   = (state_q == S_DONE) && cmd.ev_end;
  assign evt_err_o   = (state_q == S_ERR);
  assign cur_src_o   = src_q;
  assign cur_tgt_o   = tgt_q;

  // R14: a pending request holds still until it is answered
  a_r14_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i && !mem_err_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R2: descriptor fetches are aligned word reads
  a_r2_fetch_word: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FETCH) |-> (!mem_we_o && mem_size_o == 2'd2 && mem_addr_o[1:0] == 2'b00));

  // R6: a zero-length descriptor goes straight to completion
  a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LOAD && cmd.len == '0 && !abort_i) |=> (state_q == S_DONE));

  // R12: an error leaves the channel idle and quiet
  a_r12_err_halt: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err_o |=> (!busy_o && !mem_req_o));

  // R11: a paced burst only starts after a request
  a_r11_paced: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RD && $past(state_q) == S_BURST && pace) |-> $past(req_valid_i));

  // R5: no write beat is issued once the count is used up
  a_r5_no_extra_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> (rem_q != '0));

endmodule

// File: tb/sim_ldma_channel.sv
module sim_ldma_channel;

  localparam int MEMSZ = 2048;
  localparam int MASK  = MEMSZ - 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        go, abort, req_valid;
  logic [31:0] head;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        busy, evs, eve, everr;
  logic [31:0] cur_src, cur_tgt;

  logic [7:0]  mem   [0:MEMSZ-1];
  logic [7:0]  exp_m [0:MEMSZ-1];
  logic        stall_q = 1'b0;
  logic        stall_en = 1'b0;
  logic        err_en = 1'b0;
  logic [31:0] err_lo = '0, err_hi = '0;
  logic        hit;
  int          n_checks = 0, n_err = 0;
  int          st_cnt = 0, end_cnt = 0, err_cnt = 0, wr_beats = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  ldma_channel u0 (
    .clk(clk), .rst_n(rst_n), .go_i(go), .head_addr_i(head), .abort_i(abort),
    .req_valid_i(req_valid), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_size_o(mem_size), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .mem_err_i(mem_err),
    .busy_o(busy), .evt_start_o(evs), .evt_end_o(eve), .evt_err_o(everr),
    .cur_src_o(cur_src), .cur_tgt_o(cur_tgt)
  );

  function automatic logic [31:0] rd32(input logic [31:0] a);
    int i;
    i = int'(a) & MASK;
    return {mem[(i+3)&MASK], mem[(i+2)&MASK], mem[(i+1)&MASK], mem[i]};
  endfunction

  assign hit       = err_en && (mem_addr >= err_lo) && (mem_addr <= err_hi);
  assign mem_ack   = mem_req && !stall_q && !hit;
  assign mem_err   = mem_req && !stall_q && hit;
  assign mem_rdata = rd32(mem_addr);

  // Memory write side and event monitor, away from the active edge
  always @(negedge clk) begin
    stall_q = stall_en ? ($urandom_range(0, 3) == 0) : 1'b0;
    if (rst_n === 1'b1) begin
      if (mem_req && mem_we && !stall_q && !hit) begin
        for (int b = 0; b < (mem_size == 2'd0 ? 1 : mem_size == 2'd1 ? 2 : 4); b++)
          mem[(int'(mem_addr) + b) & MASK] = mem_wdata[8*b +: 8];
        wr_beats++;
      end
      if (evs)   st_cnt++;
      if (eve)   end_cnt++;
      if (everr) err_cnt++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mkcmd(input bit is, input bit it, input bit ps,
                                        input bit pt, input bit es, input bit ee,
                                        input bit sw, input int bcode, input int wcode,
                                        input int len);
    logic [31:0] c;
    c = '0;
    c[31] = is; c[30] = it; c[29] = ps; c[28] = pt;
    c[22] = es; c[21] = ee; c[18] = sw;
    c[17:16] = 2'(bcode); c[15:14] = 2'(wcode); c[12:0] = 13'(len);
    return c;
  endfunction

  task automatic put32(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[(a + b) & MASK] = v[8*b +: 8];
  endtask

  task automatic put_desc(input int a, input logic [31:0] nxt, input logic [31:0] s,
                          input logic [31:0] t, input logic [31:0] c);
    put32(a, nxt); put32(a + 4, s); put32(a + 8, t); put32(a + 12, c);
  endtask

  task automatic snap_exp();
    for (int i = 0; i < MEMSZ; i++) exp_m[i] = mem[i];
  endtask

  // Expected effect of one descriptor, derived from the requirements
  task automatic model_copy(input int s0, input int t0, input bit is, input bit it,
                            input bit sw, input int wcode, input int len);
    int w, nb, s, t;
    w  = (wcode == 1) ? 1 : (wcode == 2) ? 2 : 4;
    nb = (len + w - 1) / w;
    for (int k = 0; k < nb; k++) begin
      s = s0 + (is ? k * w : 0);
      t = t0 + (it ? k * w : 0);
      for (int b = 0; b < w; b++)
        exp_m[(t + (sw ? (w - 1 - b) : b)) & MASK] = exp_m[(s + b) & MASK];
    end
  endtask

  task automatic check_mem(input string req, input string what);
    int bad;
    bad = -1;
    for (int i = 0; i < MEMSZ; i++)
      if (bad < 0 && mem[i] !== exp_m[i]) bad = i;
    if (bad < 0) chk(1'b1, req, what, 0, 0);
    else chk(1'b0, req, $sformatf("%s byte 0x%0h", what, bad), mem[bad], exp_m[bad]);
  endtask

  task automatic wait_idle(input int lim);
    int c;
    c = 0;
    while (busy && c < lim) begin tick(1); c++; end
    if (busy) chk(1'b0, "R7", "timeout waiting for idle", 1, 0);
  endtask

  task automatic launch(input int a);
    head = 32'(a);
    go = 1'b1;
    tick(1);
    go = 1'b0;
    tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    int s0, e0, w0, c, wc, w, len, so, to;
    bit is, it, sw;
    void'($urandom(32'd4242));
    rst_n = 1'b0; go = 1'b0; abort = 1'b0; req_valid = 1'b0; head = '0;
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'h00;
    for (int i = 'h200; i < 'h400; i++) mem[i] = 8'($urandom);
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1: idle after reset
    chk(!busy, "R1", "busy after reset", busy, 0);
    chk(!mem_req, "R1", "mem_req after reset", mem_req, 0);
    chk(!evs && !eve && !everr, "R1", "events after reset", {evs, eve, everr}, 0);

    // R2 R3 R4 R9: one word-wide copy, stop flag set
    stall_en = 1'b1;
    put_desc('h000, 32'h1, 32'h200, 32'h400, mkcmd(1, 1, 0, 0, 1, 1, 0, 0, 3, 32));
    snap_exp();
    model_copy('h200, 'h400, 1, 1, 0, 3, 32);
    s0 = st_cnt; e0 = end_cnt; w0 = wr_beats;
    launch('h000);
    wait_idle(5000);
    check_mem("R3", "single word copy");
    chk(wr_beats - w0 == 8, "R2", "beats for 32 bytes of words", wr_beats - w0, 8);
    chk(st_cnt - s0 == 1, "R9", "start events", st_cnt - s0, 1);
    chk(end_cnt - e0 == 1, "R9", "end events", end_cnt - e0, 1);
    chk(!busy, "R7", "idle after stop flag", busy, 0);

    // R7 R6 R5: chain with masked pointers, empty middle, odd length
    put_desc('h000, 32'h2A, 32'h210, 32'h440, mkcmd(1, 1, 0, 0, 1, 1, 0, 0, 2, 24));
    put_desc('h020, 32'h4E, 32'h260, 32'h480, mkcmd(1, 1, 0, 0, 0, 0, 0, 0, 1, 0));
    put_desc('h040, 32'h1, 32'h270, 32'h4A0, mkcmd(1, 1, 0, 0, 0, 1, 0, 0, 3, 10));
    snap_exp();
    model_copy('h210, 'h440, 1, 1, 0, 2, 24);
    model_copy('h270, 'h4A0, 1, 1, 0, 3, 10);
    s0 = st_cnt; e0 = end_cnt; w0 = wr_beats;
    launch('h000);
    wait_idle(5000);
    check_mem("R7", "three-descriptor chain");
    chk(wr_beats - w0 == 15, "R6", "beats in chain with empty descriptor", wr_beats - w0, 15);
    chk(end_cnt - e0 == 2, "R9", "end events in chain", end_cnt - e0, 2);
    chk(st_cnt - s0 == 1, "R9", "start events in chain", st_cnt - s0, 1);

    // R4 R10: fixed source, half-word, reversed bytes
    put_desc('h000, 32'h1, 32'h2F0, 32'h500, mkcmd(0, 1, 0, 0, 0, 1, 1, 0, 2, 8));
    snap_exp();
    model_copy('h2F0, 'h500, 0, 1, 1, 2, 8);
    launch('h000);
    wait_idle(5000);
    check_mem("R4", "fixed source with byte reversal");

    // R3 R4 R10: random single descriptors
    for (int n = 0; n < 30; n++) begin
      wc  = $urandom_range(0, 3);
      w   = (wc == 1) ? 1 : (wc == 2) ? 2 : 4;
      len = w * $urandom_range(1, 16);
      is  = 1'($urandom); it = 1'($urandom); sw = 1'($urandom);
      so  = 'h200 + $urandom_range(0, 'h180);
      to  = 'h400 + $urandom_range(0, 'h200);
      put_desc('h060, 32'h1, 32'(so), 32'(to), mkcmd(is, it, 0, 0, 0, 1, sw, 0, wc, len));
      snap_exp();
      model_copy(so, to, is, it, sw, wc, len);
      e0 = end_cnt;
      launch('h060);
      wait_idle(5000);
      check_mem("R10", $sformatf("random copy %0d", n));
      chk(end_cnt - e0 == 1, "R9", "random end event", end_cnt - e0, 1);
    end

    // R8: endless ring stopped by abort
    put_desc('h080, 32'hA0, 32'h200, 32'h600, mkcmd(1, 1, 0, 0, 0, 1, 0, 0, 3, 16));
    put_desc('h0A0, 32'h80, 32'h220, 32'h610, mkcmd(1, 1, 0, 0, 0, 1, 0, 0, 3, 16));
    snap_exp();
    model_copy('h200, 'h600, 1, 1, 0, 3, 16);
    model_copy('h220, 'h610, 1, 1, 0, 3, 16);
    e0 = end_cnt;
    launch('h080);
    c = 0;
    while ((end_cnt - e0) < 5 && c < 5000) begin tick(1); c++; end
    chk(end_cnt - e0 >= 5, "R8", "ring keeps cycling", end_cnt - e0, 5);
    chk(busy, "R8", "ring still busy", busy, 1);
    abort = 1'b1;
    wait_idle(2000);
    abort = 1'b0;
    chk(!busy, "R8", "abort stops ring", busy, 0);
    check_mem("R8", "ring data");

    // R11 R13: paced transfer, 8-byte bursts
    stall_en = 1'b0;
    put_desc('h000, 32'h1, 32'h300, 32'h700, mkcmd(1, 1, 1, 0, 0, 1, 0, 1, 3, 32));
    snap_exp();
    model_copy('h300, 'h700, 1, 1, 0, 3, 32);
    w0 = wr_beats;
    launch('h000);
    tick(40);
    chk(wr_beats - w0 == 0, "R11", "no beat without request", wr_beats - w0, 0);
    req_valid = 1'b1;
    tick(1);
    req_valid = 1'b0;
    tick(30);
    chk(wr_beats - w0 == 2, "R11", "one burst per request", wr_beats - w0, 2);
    chk(cur_src == 32'h308, "R13", "live source address", cur_src, 32'h308);
    chk(cur_tgt == 32'h708, "R13", "live target address", cur_tgt, 32'h708);
    req_valid = 1'b1;
    wait_idle(5000);
    req_valid = 1'b0;
    check_mem("R11", "paced data");

    // R12: error response on a target write
    stall_en = 1'b1;
    err_en = 1'b1; err_lo = 32'h780; err_hi = 32'h783;
    put_desc('h000, 32'h1, 32'h200, 32'h740, mkcmd(1, 1, 0, 0, 0, 1, 0, 0, 3, 128));
    snap_exp();
    model_copy('h200, 'h740, 1, 1, 0, 3, 64);
    w0 = wr_beats; c = err_cnt; e0 = end_cnt;
    launch('h000);
    wait_idle(5000);
    tick(20);
    chk(err_cnt - c == 1, "R12", "error event", err_cnt - c, 1);
    chk(!busy, "R12", "halted after error", busy, 0);
    chk(wr_beats - w0 == 16, "R12", "no access after error", wr_beats - w0, 16);
    chk(end_cnt - e0 == 0, "R12", "no end event after error", end_cnt - e0, 0);
    check_mem("R12", "data before error");
    err_en = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule